// File: doc/BRIEF.md
# Copy-on-Write Versioned Memory Controller

This block sits in front of a small word-addressed memory and keeps up to sixteen frozen views of it next to the live contents. The upper four bits of every address pick the view. View 0 is the live memory. Views 1 to 15 are read-only images of memory taken at the moment software asked for them. Software takes and drops views by writing a control register. That register sits in a separate register window, selected by a request flag.

Memory is split into fixed blocks of several words. The first live write to a block after one or more views were taken copies the whole old block into a small associative store. Each saved block carries a bit vector of all the views it belongs to, so one copy serves several views that were taken before the same write. A read of an older view returns the saved copy when one exists, and live memory otherwise. Dropping a view starts a background walk that clears that view's bit in every store entry, one entry per cycle. An entry whose vector becomes empty is free again. The register bit clears only when the walk ends.

A single request channel carries reads, writes and register commands. The channel uses a valid/ready handshake, and a requester may withdraw a request that has not been accepted.

Top module: `snap_cow_ctrl`

## Requirements
- R1: After reset the view register and the overflow flag read as zero, no response is valid, and every live word reads as zero.
- R2: A register-window write with wdata[4]=1 takes the view named by wdata[3:0]; with wdata[4]=0 it drops that view. A command naming view 0 has no effect. A register-window read returns the 16-bit view register in bits 15:0 (bit X set means view X is held) and the overflow flag in bit 16, with all other bits zero.
- R3: Reads and writes with address bits 8:5 equal to 0 access live memory. The address is laid out as bits 8:5 view, bits 4:2 block, bits 1:0 word within the block.
- R4: A read of a held view returns each word as it was when that view was taken, whatever live writes followed.
- R5: Views taken at different times each see their own image. Views taken with no write between them share one saved copy and see the same image.
- R6: A write whose view field is nonzero is accepted and changes neither live memory nor any view.
- R7: After a drop, the view's register bit clears once the background walk over all store entries has finished. From then on, reads of that view return live memory.
- R8: While a walk is running, a take of the view being dropped and any further drop are held off (ready low) until the walk completes.
- R9: A live write that needs a new store entry when none is free is held off and sets a sticky overflow flag. Once a walk frees entries, the write is accepted. A write is never held off while a free entry exists.
- R10: A read response (valid with data) appears exactly one cycle after the read is accepted. Writes and commands produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at the next rising edge when valid |
| req_write | input | 1 | 1 write or command, 0 read |
| req_ctl | input | 1 | Selects the register window instead of memory |
| req_addr | input | 9 | View, block and word fields |
| req_wdata | input | 32 | Write data, or command (bit 4 take/drop, bits 3:0 view) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |

## Verification
Ready is combinational, so the bench drives at the falling edge, settles briefly and samples ready before the rising edge that accepts the request. Read data is due one cycle after acceptance, and it is checked at the falling edge that follows that acceptance edge. A take is visible to the next register read. A drop is visible only after the sixteen-cycle walk plus one edge, so the bench waits that long before it reads the register or expects live data from the dropped view. The stall case for a retake during the walk is checked in the cycle right after the drop is accepted.

// File: rtl/snap_pkg.sv
package snap_pkg;
   // Command kind carried in the register-window write data
   typedef enum logic {
      SNAP_OP_DROP = 1'b0,
      SNAP_OP_TAKE = 1'b1
   } snap_op_e;
endpackage

// File: rtl/snap_live_mem.sv
module snap_live_mem #(
   parameter  int BLK_BITS       = 3,
   parameter  int WSEL_BITS      = 2,
   parameter  int DATA_W         = 32,
   parameter  bit CLEAR_ON_RESET = 1'b1,
   localparam int BLOCKS         = 1 << BLK_BITS,
   localparam int BLK_DW         = (1 << WSEL_BITS) * DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BLK_BITS-1:0]  blk,
   input  logic                 we,
   input  logic [WSEL_BITS-1:0] wsel,
   input  logic [DATA_W-1:0]    wdata,
   output logic [BLK_DW-1:0]    blk_data
);
   logic [BLK_DW-1:0] mem_q [BLOCKS];

   assign blk_data = mem_q[blk];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int b = 0; b < BLOCKS; b++) mem_q[b] <= '0;
            end else if (we) begin
               mem_q[blk][wsel*DATA_W +: DATA_W] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem_q[blk][wsel*DATA_W +: DATA_W] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/snap_ctrl_reg.sv
module snap_ctrl_reg
   import snap_pkg::*;
#(
   parameter  int SNAP_BITS = 4,
   parameter  int ENTRIES   = 16,
   localparam int NUM_SNAP  = 1 << SNAP_BITS,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_fire,
   input  snap_op_e             cmd_op,
   input  logic [SNAP_BITS-1:0] cmd_id,
   output logic [NUM_SNAP-1:0]  snap_reg,
   output logic [NUM_SNAP-1:0]  active_mask,
   output logic                 busy,
   output logic [SNAP_BITS-1:0] sweep_id,
   output logic [IDX_W-1:0]     sweep_idx
);
   logic [NUM_SNAP-1:0]  snap_q, snap_d, sweep_oh;
   logic                 busy_q, rel_start, last;
   logic [SNAP_BITS-1:0] sid_q;
   logic [IDX_W-1:0]     idx_q;

   assign sweep_oh = busy_q ? (NUM_SNAP'(1) << sid_q) : '0;
   assign last     = busy_q && (idx_q == IDX_W'(ENTRIES - 1));

   always_comb begin
      snap_d    = snap_q;
      rel_start = 1'b0;
      if (cmd_fire && cmd_id != '0) begin
         if (cmd_op == SNAP_OP_TAKE) snap_d[cmd_id] = 1'b1;
         else if (snap_q[cmd_id] && !busy_q) rel_start = 1'b1;
      end
      if (last) snap_d[sid_q] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         busy_q <= 1'b0;
         sid_q  <= '0;
         idx_q  <= '0;
      end else begin
         snap_q <= snap_d;
         if (rel_start) begin
            busy_q <= 1'b1;
            sid_q  <= cmd_id;
            idx_q  <= '0;
         end else if (last) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign snap_reg    = snap_q;
   assign active_mask = snap_q & ~sweep_oh;
   assign busy        = busy_q;
   assign sweep_id    = sid_q;
   assign sweep_idx   = idx_q;

   // R7: the view bit is gone right after the walk's final entry
   p_drop_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (snap_q[$past(sid_q)] == 1'b0));

   // R8: a running walk keeps its target until it ends
   p_walk_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> (busy_q && $stable(sid_q)));

   // R2: view 0 can never be held
   p_view0_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      snap_q[0] == 1'b0);
endmodule

// File: rtl/snap_store.sv
module snap_store #(
   parameter  int NUM_SNAP = 16,
   parameter  int BLK_BITS = 3,
   parameter  int BLK_DW   = 128,
   parameter  int ENTRIES  = 16,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int SID_W    = $clog2(NUM_SNAP)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BLK_BITS-1:0] look_blk,
   input  logic [SID_W-1:0]    rd_sid,
   input  logic                alloc_en,
   input  logic [NUM_SNAP-1:0] alloc_vec,
   input  logic [BLK_DW-1:0]   alloc_data,
   input  logic                sweep_en,
   input  logic [IDX_W-1:0]    sweep_idx,
   input  logic [SID_W-1:0]    sweep_sid,
   output logic [NUM_SNAP-1:0] held_mask,
   output logic                hit,
   output logic [BLK_DW-1:0]   hit_data,
   output logic                free_any
);
   logic [ENTRIES-1:0]  free_vec, hit_vec;
   logic [NUM_SNAP-1:0] held_part [ENTRIES];
   logic [BLK_DW-1:0]   hit_part  [ENTRIES];
   logic [IDX_W-1:0]    alloc_idx;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         logic [NUM_SNAP-1:0] vec_q;
         logic [BLK_BITS-1:0] blk_q;
         logic [BLK_DW-1:0]   dat_q;
         logic                match;

         assign free_vec[e]  = (vec_q == '0);
         assign match        = !free_vec[e] && (blk_q == look_blk);
         assign hit_vec[e]   = match && vec_q[rd_sid];
         assign held_part[e] = match ? vec_q : '0;
         assign hit_part[e]  = hit_vec[e] ? dat_q : '0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vec_q <= '0;
               blk_q <= '0;
               dat_q <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(e)) begin
               vec_q <= alloc_vec;
               blk_q <= look_blk;
               dat_q <= alloc_data;
            end else if (sweep_en && sweep_idx == IDX_W'(e)) begin
               vec_q[sweep_sid] <= 1'b0;
            end
         end

         // R7: the walk removes its view from the entry it visits
         p_sweep_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sweep_en && sweep_idx == IDX_W'(e)) |=> (vec_q[$past(sweep_sid)] == 1'b0));
      end
   endgenerate

   always_comb begin
      held_mask = '0;
      hit_data  = '0;
      alloc_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         held_mask = held_mask | held_part[e];
         hit_data  = hit_data | hit_part[e];
      end
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (free_vec[e]) alloc_idx = IDX_W'(e);
      end
   end

   assign hit      = |hit_vec;
   assign free_any = |free_vec;

   // R5: at most one saved copy answers a given block and view
   p_single_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R9: a copy is only ever placed into a free slot
   p_alloc_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> free_any);
endmodule

// File: rtl/snap_cow_ctrl.sv
module snap_cow_ctrl
   import snap_pkg::*;
#(
   parameter  int SNAP_BITS      = 4,
   parameter  int BLK_BITS       = 3,
   parameter  int WSEL_BITS      = 2,
   parameter  int DATA_W         = 32,
   parameter  int ENTRIES        = 16,
   parameter  bit CLEAR_ON_RESET = 1'b1,
   localparam int ADDR_W         = SNAP_BITS + BLK_BITS + WSEL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_ctl,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   localparam int NUM_SNAP = 1 << SNAP_BITS;
   localparam int BLK_DW   = (1 << WSEL_BITS) * DATA_W;
   localparam int IDX_W    = $clog2(ENTRIES);

   generate
      if (SNAP_BITS != 4) begin : g_bad_snap
         $error("snap_cow_ctrl: exactly 16 views are supported");
      end
      if (DATA_W < NUM_SNAP + 1) begin : g_bad_dw
         $error("snap_cow_ctrl: data width too small for the view register");
      end
      if (ENTRIES < 2) begin : g_bad_ent
         $error("snap_cow_ctrl: store needs at least two entries");
      end
      if (WSEL_BITS < 1 || BLK_BITS < 1) begin : g_bad_geo
         $error("snap_cow_ctrl: block geometry fields must be nonzero");
      end
   endgenerate

   logic [SNAP_BITS-1:0] sid;
   logic [BLK_BITS-1:0]  blk;
   logic [WSEL_BITS-1:0] wsel;
   assign sid  = req_addr[ADDR_W-1 -: SNAP_BITS];
   assign blk  = req_addr[WSEL_BITS +: BLK_BITS];
   assign wsel = req_addr[WSEL_BITS-1:0];

   snap_op_e             cmd_op;
   logic [SNAP_BITS-1:0] cmd_id;
   assign cmd_op = snap_op_e'(req_wdata[SNAP_BITS]);
   assign cmd_id = req_wdata[SNAP_BITS-1:0];

   logic [NUM_SNAP-1:0]  snap_reg, active_mask, held_mask, need;
   logic                 busy, hit, free_any, ovf_q;
   logic [SNAP_BITS-1:0] sweep_id;
   logic [IDX_W-1:0]     sweep_idx;
   logic [BLK_DW-1:0]    live_blk, hit_blk;
   logic                 wr_live, ctl_fire, rd_fire, mem_we, alloc_en;

   assign wr_live  = req_valid && req_write && !req_ctl && (sid == '0);
   assign need     = active_mask & ~held_mask;

   always_comb begin
      req_ready = 1'b1;
      if (req_ctl && req_write) begin
         if (cmd_op == SNAP_OP_TAKE) req_ready = !(busy && cmd_id == sweep_id);
         else                        req_ready = !busy;
      end else if (wr_live) begin
         req_ready = (need == '0) || free_any;
      end
   end

   assign ctl_fire = req_valid && req_ready && req_ctl && req_write;
   assign rd_fire  = req_valid && req_ready && !req_write;
   assign mem_we   = wr_live && req_ready;
   assign alloc_en = mem_we && (need != '0);

   snap_ctrl_reg #(.SNAP_BITS(SNAP_BITS), .ENTRIES(ENTRIES)) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_fire    (ctl_fire),
      .cmd_op      (cmd_op),
      .cmd_id      (cmd_id),
      .snap_reg    (snap_reg),
      .active_mask (active_mask),
      .busy        (busy),
      .sweep_id    (sweep_id),
      .sweep_idx   (sweep_idx)
   );

   snap_store #(.NUM_SNAP(NUM_SNAP), .BLK_BITS(BLK_BITS), .BLK_DW(BLK_DW),
                .ENTRIES(ENTRIES)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_blk   (blk),
      .rd_sid     (sid),
      .alloc_en   (alloc_en),
      .alloc_vec  (need),
      .alloc_data (live_blk),
      .sweep_en   (busy),
      .sweep_idx  (sweep_idx),
      .sweep_sid  (sweep_id),
      .held_mask  (held_mask),
      .hit        (hit),
      .hit_data   (hit_blk),
      .free_any   (free_any)
   );

   snap_live_mem #(.BLK_BITS(BLK_BITS), .WSEL_BITS(WSEL_BITS), .DATA_W(DATA_W),
                   .CLEAR_ON_RESET(CLEAR_ON_RESET)) i_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .blk      (blk),
      .we       (mem_we),
      .wsel     (wsel),
      .wdata    (req_wdata),
      .blk_data (live_blk)
   );

   logic [DATA_W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      if (req_ctl)                rd_word[NUM_SNAP:0] = {ovf_q, snap_reg};
      else if (sid != '0 && hit)  rd_word = hit_blk[wsel*DATA_W +: DATA_W];
      else                        rd_word = live_blk[wsel*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         ovf_q     <= 1'b0;
      end else begin
         rsp_valid <= rd_fire;
         if (rd_fire) rsp_data <= rd_word;
         if (wr_live && need != '0 && !free_any) ovf_q <= 1'b1;
      end
   end

   // R10: a response follows exactly one accepted read
   p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready && !req_write));

   // R9: overflow stays set once raised
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
endmodule

// File: tb/test_snap_cow_ctrl.sv
module test_snap_cow_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int EN = 16;
   localparam int NW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_ctl = 1'b0;
   logic [8:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_data;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   logic [31:0] live_m [NW];
   logic [31:0] img    [16][NW];
   bit          taken  [16];
   bit          ovf_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   snap_cow_ctrl i_snap_cow_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_ctl(req_ctl), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
   endtask

   function automatic logic [31:0] exp_read(input int s, input int idx);
      if (s == 0 || !taken[s]) return live_m[idx];
      return img[s][idx];
   endfunction

   function automatic logic [31:0] exp_ctl();
      logic [31:0] v = '0;
      for (int i = 1; i < 16; i++) v[i] = taken[i];
      v[16] = ovf_m;
      return v;
   endfunction

   // Called at a falling edge; returns at the falling edge after acceptance
   task automatic issue(input bit c, input bit w, input logic [8:0] a,
                        input logic [31:0] d, input int maxw,
                        output bit acc, output int waited);
      req_valid = 1'b1; req_ctl = c; req_write = w; req_addr = a; req_wdata = d;
      acc = 1'b0; waited = 0;
      while (!acc && waited < maxw) begin
         #1;
         if (req_ready) acc = 1'b1;
         @(posedge clk);
         @(negedge clk);
         if (!acc) waited++;
      end
      req_valid = 1'b0; req_write = 1'b0; req_ctl = 1'b0;
   endtask

   task automatic do_write(input int s, input int idx, input logic [31:0] d,
                           input int maxw, output bit acc);
      int wt;
      issue(1'b0, 1'b1, {4'(s), 5'(idx)}, d, maxw, acc, wt);
      if (acc && s == 0) live_m[idx] = d;
   endtask

   task automatic do_read(input int s, input int idx, input string tag);
      bit acc; int wt; logic [31:0] e;
      e = exp_read(s, idx);
      issue(1'b0, 1'b0, {4'(s), 5'(idx)}, '0, 4, acc, wt);
      check(acc && rsp_valid, {tag, " response valid"}, {31'b0, rsp_valid}, 32'd1);
      check(rsp_data === e, tag, rsp_data, e);
   endtask

   task automatic ctl_read(input string tag);
      bit acc; int wt; logic [31:0] e;
      e = exp_ctl();
      issue(1'b1, 1'b0, '0, '0, 4, acc, wt);
      check(acc && rsp_valid && rsp_data === e, tag, rsp_data, e);
   endtask

   task automatic take(input int id);
      bit acc; int wt;
      issue(1'b1, 1'b1, '0, {27'b0, 1'b1, 4'(id)}, EN + 4, acc, wt);
      check(acc, "R8 take accepted", {31'b0, acc}, 32'd1);
      if (acc && id != 0 && !taken[id]) begin
         taken[id] = 1'b1;
         for (int i = 0; i < NW; i++) img[id][i] = live_m[i];
      end
   endtask

   task automatic drop(input int id);
      bit acc; int wt;
      issue(1'b1, 1'b1, '0, {27'b0, 1'b0, 4'(id)}, EN + 4, acc, wt);
      check(acc, "R8 drop accepted", {31'b0, acc}, 32'd1);
      repeat (EN + 2) @(negedge clk);
      if (id != 0) taken[id] = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      bit acc; int wt; int seed_dummy;
      int pool [4] = '{3, 7, 9, 12};
      seed_dummy = $urandom(32'h5eed);
      for (int i = 0; i < NW; i++) live_m[i] = '0;
      for (int s = 0; s < 16; s++) taken[s] = 1'b0;
      ovf_m = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(rsp_valid === 1'b0, "R1 no response after reset", {31'b0, rsp_valid}, 32'd0);
      ctl_read("R1 view register clear");
      do_read(0, 13, "R1 live word zero");

      // R3 live access
      do_write(0, 5, 32'hA5A5_0001, 2, acc);
      do_write(0, 6, 32'h0000_BEEF, 2, acc);
      do_read(0, 5, "R3 live readback");
      do_read(0, 6, "R3 live neighbour");

      // R10 writes produce no response
      do_write(0, 7, 32'h77, 2, acc);
      check(rsp_valid === 1'b0, "R10 no response for write", {31'b0, rsp_valid}, 32'd0);

      // R2 view 0 ignored, take sets bit
      take(0);
      ctl_read("R2 take of view 0 ignored");
      take(3);
      ctl_read("R2 take sets bit 3");

      // R4 frozen image
      do_write(0, 5, 32'h1111_2222, 2, acc);
      do_read(3, 5, "R4 view 3 keeps old word");
      do_read(0, 5, "R4 live sees new word");
      do_read(3, 6, "R4 view 3 same block other word");

      // R5 separate and shared views
      take(6);
      do_write(0, 5, 32'h3333_4444, 2, acc);
      do_read(3, 5, "R5 oldest view");
      do_read(6, 5, "R5 later view");
      take(10);
      take(11);
      do_write(0, 20, 32'hCAFE_0020, 2, acc);
      do_read(10, 20, "R5 shared copy view 10");
      do_read(11, 20, "R5 shared copy view 11");

      // R6 writes to nonzero views ignored
      do_write(3, 5, 32'hDEAD_DEAD, 2, acc);
      check(acc, "R6 write to view accepted", {31'b0, acc}, 32'd1);
      do_read(3, 5, "R6 view unchanged");
      do_read(0, 5, "R6 live unchanged");

      // R8 retake during walk stalls
      issue(1'b1, 1'b1, '0, {27'b0, 1'b0, 4'd3}, 2, acc, wt);
      taken[3] = 1'b0;
      issue(1'b1, 1'b1, '0, {27'b0, 1'b1, 4'd3}, 1, acc, wt);
      check(!acc, "R8 retake held off during walk", {31'b0, acc}, 32'd0);
      issue(1'b1, 1'b1, '0, {27'b0, 1'b0, 4'd6}, 1, acc, wt);
      check(!acc, "R8 second drop held off", {31'b0, acc}, 32'd0);
      take(3);
      ctl_read("R8 retake after walk");
      do_read(3, 5, "R8 retaken view shows current data");

      // R7 drop clears bit and view falls back to live
      drop(6);
      ctl_read("R7 bit clear after walk");
      do_read(6, 5, "R7 dropped view reads live");
      drop(3); drop(10); drop(11);
      ctl_read("R7 all views dropped");

      // Random phase: R3, R4, R6, R9 (never stall with room)
      for (int n = 0; n < 500; n++) begin
         int op; int idx; int cnt; int s;
         op  = int'($urandom % 100);
         idx = int'($urandom % NW);
         cnt = 0;
         for (int k = 0; k < 4; k++) cnt += taken[pool[k]];
         if (op < 45) begin
            do_write(0, idx, $urandom, 3, acc);
            check(acc, "R9 write not held with free entries", {31'b0, acc}, 32'd1);
         end else if (op < 80) begin
            s = ($urandom % 3 == 0) ? 0 : pool[$urandom % 4];
            do_read(s, idx, "R4 random read");
         end else if (op < 88) begin
            s = pool[$urandom % 4];
            if (cnt < 2 && !taken[s]) take(s);
         end else if (op < 95) begin
            s = pool[$urandom % 4];
            if (taken[s]) drop(s);
         end else begin
            s = pool[$urandom % 4];
            do_write(s, idx, $urandom, 2, acc);
            do_read(s, idx, "R6 random ignored write");
         end
      end
      for (int k = 0; k < 4; k++) if (taken[pool[k]]) drop(pool[k]);
      ctl_read("R7 random phase cleared");

      // R9 store full
      take(1);
      for (int b = 0; b < 8; b++) do_write(0, b*4, 32'h100 + b, 3, acc);
      take(2);
      for (int b = 0; b < 8; b++) do_write(0, b*4 + 1, 32'h200 + b, 3, acc);
      take(4);
      do_write(0, 2, 32'hF00D, 3, acc);
      check(!acc, "R9 write held off when full", {31'b0, acc}, 32'd0);
      ovf_m = 1'b1;
      ctl_read("R9 overflow flag set");
      do_read(0, 2, "R9 live untouched by held write");
      drop(1);
      do_write(0, 2, 32'hF00D, 3, acc);
      check(acc, "R9 write accepted after free", {31'b0, acc}, 32'd1);
      do_read(4, 2, "R9 view keeps old word");
      do_read(0, 2, "R9 live has new word");
      do_read(2, 4, "R9 view 2 intact");
      ctl_read("R9 overflow sticky");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule